// File: doc/BRIEF.md
# Receive Descriptor Ring Writeback Engine

This block closes out received frames into a ring of receive descriptors. An upstream source hands over each completed frame as a byte count, a typed-frame flag and five error flags. The engine finds the descriptor at its current ring position. If software has handed that descriptor over by setting its ownership bit, the engine writes the frame result into the descriptor's flags word. That same word write clears the ownership bit, which returns the descriptor to software.

The ring sits in a descriptor memory inside the block. Each descriptor is eight 32-bit words, and descriptor `i` starts at word address `8*i`. Software reaches the memory through a simple word port. It prepares a descriptor by writing the size word first and then setting ownership in the flags word. It may then pulse a poll-demand strobe. If a frame completes while the current descriptor still belongs to software, the engine stalls the source and holds the frame. It checks the descriptor again only after a poll demand.

Top module: `rxwb_engine`

## Requirements
- R1: After reset `frm_stall` is low, every descriptor memory word reads zero, and the first frame goes to descriptor 0.
- R2: A frame written back to an owned descriptor leaves that descriptor's flags word with bit 31 (ownership) clear, bit 9 (first segment) and bit 8 (last segment) set, and the recorded length in bits 29:16.
- R3: An untyped frame records `frm_len` unchanged. A typed frame sets flags bit 5 and records `frm_len + 4`, so the 4-byte trailer is included.
- R4: A recorded length that would pass 16383 is held at 16383.
- R5: Error input bits map onto flags bits as follows: `frm_err[0]`→1 (CRC), `[1]`→3 (receive), `[2]`→11 (overflow), `[3]`→12 (length), `[4]`→7 (giant). Bit 15 is set exactly when any error input is set. All other flags bits are zero.
- R6: A writeback changes only word 0 of the descriptor. The size word (word 1) and words 2 to 7 keep their contents.
- R7: After a writeback the engine moves on to the next descriptor. It returns to descriptor 0 after a descriptor whose size word has bit 15 (end of ring) set, and after the last physical descriptor.
- R8: A frame that completes while the current descriptor is not owned raises `frm_stall`, writes nothing, and stays held. Neither new input frames nor a poll demand while ownership is still clear replace it or release it.
- R9: If software sets ownership while the engine waits, the held frame is written only after the next `poll_req` pulse. `frm_stall` falls in the cycle after that write.
- R10: A `poll_req` while no frame is pending writes nothing and leaves `frm_stall` low.
- R11: A frame is taken on a clock edge where `frm_valid` is high and `frm_stall` is low. `frm_stall` is high from the next cycle until the writeback cycle, so each frame occupies at least two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_valid | input | 1 | A completed frame is offered |
| frm_len | input | 14 | Frame byte count without trailer |
| frm_typed | input | 1 | Frame is typed and carries the 4-byte trailer |
| frm_err | input | 5 | Error flags: CRC, receive, overflow, length, giant |
| frm_stall | output | 1 | Engine busy or waiting for a descriptor; source must hold |
| poll_req | input | 1 | Poll demand: re-check the current descriptor |
| sw_we | input | 1 | Software word write enable |
| sw_addr | input | clog2(DEPTH)+3 | Software word address |
| sw_wdata | input | 32 | Software write data |
| sw_rdata | output | 32 | Software read data, one cycle after the address |

## Verification
The assertions assume a source that offers a frame only through `frm_valid` and that treats `frm_stall` as back-pressure. They also assume software never writes the flags word of the descriptor the engine is writing back in that same cycle. The stimulus respects both. Every software write and every frame is driven on the falling edge, and a frame stays offered until a falling edge shows `frm_stall` low. Descriptors are prepared only at the slot the bench expects the engine to reach next, or while the engine is parked in its wait state.

// File: rtl/rxwb_pkg.sv
package rxwb_pkg;
   localparam int WORD_W       = 32;
   localparam int DESC_WORDS   = 8;
   localparam int OFF_W        = 3;
   localparam int FLAGS_WORD   = 0;
   localparam int SIZE_WORD    = 1;
   localparam int OWN_BIT      = 31;
   localparam int RING_END_BIT = 15;
   localparam int LEN_LSB      = 16;
   localparam int LEN_W        = 14;
   localparam int FIRST_BIT    = 9;
   localparam int LAST_BIT     = 8;
   localparam int TYPED_BIT    = 5;
   localparam int SUMM_BIT     = 15;
   localparam int ERR_N        = 5;

   typedef logic [ERR_N-1:0] err_vec_t;

   typedef struct packed {
      logic [LEN_W-1:0] len;
      logic             typed;
      err_vec_t         err;
   } frame_t;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_CHECK = 2'd1,
      ST_WAIT  = 2'd2
   } wb_state_e;

   // flags bit position for each error input index
   function automatic int err_bit_pos(input int idx);
      case (idx)
         0:       return 1;
         1:       return 3;
         2:       return 11;
         3:       return 12;
         default: return 7;
      endcase
   endfunction
endpackage

// File: rtl/rxwb_status_fmt.sv
module rxwb_status_fmt import rxwb_pkg::*; #(
   parameter int TRAILER_BYTES = 4,
   parameter bit LEN_SATURATE  = 1'b1
) (
   input  frame_t            frm,
   output logic [WORD_W-1:0] flags
);
   localparam int               SUM_W   = LEN_W + 1;
   localparam logic [LEN_W-1:0] LEN_MAX = '1;

   logic [SUM_W-1:0] len_sum;
   logic [LEN_W-1:0] len_rec;

   always_comb
      len_sum = {1'b0, frm.len} + (frm.typed ? SUM_W'(TRAILER_BYTES) : SUM_W'(0));

   generate
      if (LEN_SATURATE) begin : g_sat
         assign len_rec = len_sum[LEN_W] ? LEN_MAX : len_sum[LEN_W-1:0];
      end else begin : g_wrap
         logic carry_unused;
         assign carry_unused = len_sum[LEN_W];
         assign len_rec      = len_sum[LEN_W-1:0];
      end
   endgenerate

   always_comb begin
      flags                      = '0;
      flags[LEN_LSB +: LEN_W]    = len_rec;
      flags[FIRST_BIT]           = 1'b1;
      flags[LAST_BIT]            = 1'b1;
      flags[TYPED_BIT]           = frm.typed;
      for (int i = 0; i < ERR_N; i++)
         flags[err_bit_pos(i)]   = frm.err[i];
      flags[SUMM_BIT]            = |frm.err;
      flags[OWN_BIT]             = 1'b0;
   end
endmodule

// File: rtl/rxwb_ring_ptr.sv
module rxwb_ring_ptr #(
   parameter int DEPTH = 4,
   parameter int IDX_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   input  logic             end_mark,
   output logic [IDX_W-1:0] idx
);
   localparam bit IS_POW2 = (DEPTH == (1 << IDX_W));

   logic [IDX_W-1:0] idx_q, idx_nxt;

   generate
      if (IS_POW2) begin : g_pow2
         always_comb idx_nxt = end_mark ? '0 : idx_q + 1'b1;
      end else begin : g_cmp
         logic at_last;
         assign at_last = (idx_q == IDX_W'(DEPTH - 1));
         always_comb idx_nxt = (end_mark || at_last) ? '0 : idx_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   idx_q <= '0;
      else if (adv) idx_q <= idx_nxt;
   end

   assign idx = idx_q;

   // R7
   idx_in_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
      idx_q <= IDX_W'(DEPTH - 1));
endmodule

// File: rtl/rxwb_desc_mem.sv
module rxwb_desc_mem import rxwb_pkg::*; #(
   parameter int DEPTH = 4,
   parameter int IDX_W = 2,
   parameter int AW    = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_we,
   input  logic [AW-1:0]     sw_addr,
   input  logic [WORD_W-1:0] sw_wdata,
   output logic [WORD_W-1:0] sw_rdata,
   input  logic [IDX_W-1:0]  eng_idx,
   output logic              eng_own,
   output logic              eng_end,
   input  logic              eng_we,
   input  logic [WORD_W-1:0] eng_wdata
);
   localparam int WORDS = DEPTH * DESC_WORDS;

   logic [WORD_W-1:0] mem [WORDS];
   logic [AW-1:0]     eng_waddr, eng_saddr;

   assign eng_waddr = {eng_idx, OFF_W'(FLAGS_WORD)};
   assign eng_saddr = {eng_idx, OFF_W'(SIZE_WORD)};
   assign eng_own   = mem[eng_waddr][OWN_BIT];
   assign eng_end   = mem[eng_saddr][RING_END_BIT];

   // engine write wins over a software write to the same word
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int w = 0; w < WORDS; w++) mem[w] <= '0;
      end else begin
         for (int w = 0; w < WORDS; w++) begin
            if (eng_we && eng_waddr == AW'(w))     mem[w] <= eng_wdata;
            else if (sw_we && sw_addr == AW'(w))  mem[w] <= sw_wdata;
         end
      end
   end

   generate
      if (WORDS == (1 << AW)) begin : g_full
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sw_rdata <= '0;
            else        sw_rdata <= mem[sw_addr];
         end
      end else begin : g_part
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                     sw_rdata <= '0;
            else if (sw_addr < AW'(WORDS))  sw_rdata <= mem[sw_addr];
            else                            sw_rdata <= '0;
         end
      end
   endgenerate

   // R2
   eng_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eng_we |=> (mem[$past(eng_waddr)] == $past(eng_wdata)));
endmodule

// File: rtl/rxwb_ctrl.sv
module rxwb_ctrl import rxwb_pkg::*; (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   frm_valid,
   input  frame_t frm_in,
   input  logic   poll_req,
   input  logic   own_rd,
   output logic   frm_stall,
   output frame_t pend,
   output logic   wb_we
);
   wb_state_e state_q, state_d;
   frame_t    pend_q;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (frm_valid) state_d = ST_CHECK;
         ST_CHECK: begin
            if (own_rd)        state_d = ST_IDLE;
            else if (poll_req) state_d = ST_CHECK;
            else               state_d = ST_WAIT;
         end
         ST_WAIT:  if (poll_req) state_d = ST_CHECK;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         pend_q  <= '0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_IDLE && frm_valid) pend_q <= frm_in;
      end
   end

   assign frm_stall = (state_q != ST_IDLE);
   assign wb_we     = (state_q == ST_CHECK) && own_rd;
   assign pend      = pend_q;

   // R11
   accept_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_valid && !frm_stall) |=> frm_stall);
   // R8
   wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_stall && !wb_we) |=> (frm_stall && $stable(pend)));
   // R9
   release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wb_we |=> !frm_stall);
   // R10
   idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !frm_stall |-> !wb_we);
endmodule

// File: rtl/rxwb_engine.sv
module rxwb_engine import rxwb_pkg::*; #(
   parameter int DEPTH         = 4,
   parameter int TRAILER_BYTES = 4,
   parameter bit LEN_SATURATE  = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       frm_valid,
   input  logic [13:0]                frm_len,
   input  logic                       frm_typed,
   input  logic [4:0]                 frm_err,
   output logic                       frm_stall,
   input  logic                       poll_req,
   input  logic                       sw_we,
   input  logic [$clog2(DEPTH)+2:0]   sw_addr,
   input  logic [31:0]                sw_wdata,
   output logic [31:0]                sw_rdata
);
   localparam int IDX_W = $clog2(DEPTH);
   localparam int AW    = IDX_W + OFF_W;

   generate
      if (DEPTH < 2 || DEPTH > 256) begin : g_bad_depth
         $error("rxwb_engine: DEPTH must lie in 2..256");
      end
      if (TRAILER_BYTES < 0 || TRAILER_BYTES > 15) begin : g_bad_trailer
         $error("rxwb_engine: TRAILER_BYTES must lie in 0..15");
      end
   endgenerate

   frame_t            frm_in, pend;
   logic              own_rd, end_rd, wb_we;
   logic [IDX_W-1:0]  idx;
   logic [WORD_W-1:0] wb_flags;

   always_comb begin
      frm_in.len   = frm_len;
      frm_in.typed = frm_typed;
      frm_in.err   = frm_err;
   end

   rxwb_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .frm_valid (frm_valid),
      .frm_in    (frm_in),
      .poll_req  (poll_req),
      .own_rd    (own_rd),
      .frm_stall (frm_stall),
      .pend      (pend),
      .wb_we     (wb_we)
   );

   rxwb_status_fmt #(
      .TRAILER_BYTES (TRAILER_BYTES),
      .LEN_SATURATE  (LEN_SATURATE)
   ) u_fmt (
      .frm   (pend),
      .flags (wb_flags)
   );

   rxwb_ring_ptr #(
      .DEPTH (DEPTH),
      .IDX_W (IDX_W)
   ) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .adv      (wb_we),
      .end_mark (end_rd),
      .idx      (idx)
   );

   rxwb_desc_mem #(
      .DEPTH (DEPTH),
      .IDX_W (IDX_W),
      .AW    (AW)
   ) u_mem (
      .clk       (clk),
      .rst_n     (rst_n),
      .sw_we     (sw_we),
      .sw_addr   (sw_addr),
      .sw_wdata  (sw_wdata),
      .sw_rdata  (sw_rdata),
      .eng_idx   (idx),
      .eng_own   (own_rd),
      .eng_end   (end_rd),
      .eng_we    (wb_we),
      .eng_wdata (wb_flags)
   );

   // R5
   summary_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wb_we |-> (wb_flags[SUMM_BIT] == (|pend.err)));

   generate
      if (LEN_SATURATE) begin : g_len_chk
         // R3
         len_not_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wb_we |-> (wb_flags[LEN_LSB +: LEN_W] >= pend.len));
      end
   endgenerate
endmodule

// File: tb/sim_rxwb_engine.sv
`timescale 1ns/1ps
module sim_rxwb_engine;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frm_valid = 1'b0;
   logic [13:0] frm_len = '0;
   logic        frm_typed = 1'b0;
   logic [4:0]  frm_err = '0;
   logic        frm_stall;
   logic        poll_req = 1'b0;
   logic        sw_we = 1'b0;
   logic [4:0]  sw_addr = '0;
   logic [31:0] sw_wdata = '0;
   logic [31:0] sw_rdata;

   int n_chk = 0;
   int n_fail = 0;
   int nidx = 0;
   bit endm_b [4];
   bit timed_out = 1'b0;

   rxwb_engine u0 (
      .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_len(frm_len),
      .frm_typed(frm_typed), .frm_err(frm_err), .frm_stall(frm_stall),
      .poll_req(poll_req), .sw_we(sw_we), .sw_addr(sw_addr),
      .sw_wdata(sw_wdata), .sw_rdata(sw_rdata)
   );

   initial forever #10 clk = ~clk;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_flags(input int len, input bit typed, input logic [4:0] e);
      int          l;
      logic [31:0] f;
      l = typed ? len + 4 : len;
      if (l > 16383) l = 16383;
      f = 32'h0000_0300 | (32'(l) << 16);
      if (typed) f |= 32'h0000_0020;
      if (e[0])  f |= 32'h0000_0002;
      if (e[1])  f |= 32'h0000_0008;
      if (e[2])  f |= 32'h0000_0800;
      if (e[3])  f |= 32'h0000_1000;
      if (e[4])  f |= 32'h0000_0080;
      if (e != 5'd0) f |= 32'h0000_8000;
      return f;
   endfunction

   task automatic sw_write(input int a, input logic [31:0] d);
      @(negedge clk);
      sw_we = 1'b1; sw_addr = 5'(a); sw_wdata = d;
      @(negedge clk);
      sw_we = 1'b0;
   endtask

   task automatic sw_read(input int a, output logic [31:0] d);
      @(negedge clk);
      sw_addr = 5'(a);
      @(negedge clk);
      d = sw_rdata;
   endtask

   task automatic give(input int idx, input bit em);
      endm_b[idx] = em;
      sw_write(idx * 8 + 1, em ? 32'h0000_8800 : 32'h0000_0800);
      sw_write(idx * 8, 32'h8000_0000);
   endtask

   task automatic send(input int len, input bit typed, input logic [4:0] e);
      @(negedge clk);
      frm_valid = 1'b1; frm_len = 14'(len); frm_typed = typed; frm_err = e;
      while (frm_stall) @(negedge clk);
      @(negedge clk);
      frm_valid = 1'b0;
      chk("R11 stall after accept", 32'(frm_stall), 32'd1);
   endtask

   task automatic advance();
      nidx = (endm_b[nidx] || nidx == 3) ? 0 : nidx + 1;
   endtask

   task automatic frame_ok(input int len, input bit typed, input logic [4:0] e, input string tag);
      logic [31:0] v;
      send(len, typed, e);
      @(negedge clk);
      chk("R11 stall released after writeback", 32'(frm_stall), 32'd0);
      sw_read(nidx * 8, v);
      chk(tag, v, exp_flags(len, typed, e));
      advance();
   endtask

   task automatic poll_pulse();
      @(negedge clk); poll_req = 1'b1;
      @(negedge clk); poll_req = 1'b0;
   endtask

   task automatic run_all();
      logic [31:0] v, old;
      repeat (3) @(negedge clk);
      chk("R1 stall in reset", 32'(frm_stall), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 stall after reset", 32'(frm_stall), 32'd0);
      for (int a = 0; a < 32; a++) begin
         sw_read(a, v);
         chk("R1 memory cleared", v, 32'd0);
      end

      // first pass: end-of-ring mark on descriptor 2
      give(0, 1'b0); give(1, 1'b0); give(2, 1'b1);
      frame_ok(60, 1'b0, 5'd0, "R1 R2 first frame into descriptor 0");
      frame_ok(100, 1'b1, 5'd0, "R3 typed frame adds trailer");
      frame_ok(200, 1'b0, 5'b00001, "R5 CRC error");
      chk("R7 end mark returns ring to 0", 32'(nidx), 32'd0);
      sw_read(3 * 8, v);
      chk("R7 descriptor 3 skipped", v, 32'd0);
      sw_read(1 * 8 + 1, v);
      chk("R6 size word kept", v, 32'h0000_0800);
      sw_read(2 * 8 + 1, v);
      chk("R6 end mark kept", v, 32'h0000_8800);
      for (int w = 2; w < 8; w++) begin
         sw_read(8 + w, v);
         chk("R6 spare words kept", v, 32'd0);
      end
      give(0, 1'b0);
      frame_ok(64, 1'b0, 5'd0, "R7 wrap by end mark to descriptor 0");

      // sweep of every error pattern, both types, physical wrap
      for (int e = 0; e < 32; e++) begin
         for (int t = 0; t < 2; t++) begin
            give(nidx, 1'b0);
            frame_ok(7 * e + 64 + 3 * t, t[0], 5'(e), "R5 R3 R7 sweep");
         end
      end

      // saturation
      give(nidx, 1'b0); frame_ok(16383, 1'b1, 5'd0, "R4 typed max");
      give(nidx, 1'b0); frame_ok(16380, 1'b1, 5'd0, "R4 typed overflow by one");
      give(nidx, 1'b0); frame_ok(16379, 1'b1, 5'd0, "R4 typed exact max");
      give(nidx, 1'b0); frame_ok(16383, 1'b0, 5'd0, "R4 untyped max");

      // no owned descriptor: stall, hold, poll
      sw_read(nidx * 8, old);
      send(300, 1'b1, 5'b10000);
      repeat (4) @(negedge clk);
      chk("R8 stall while not owned", 32'(frm_stall), 32'd1);
      sw_read(nidx * 8, v);
      chk("R8 nothing written", v, old);
      @(negedge clk);
      frm_valid = 1'b1; frm_len = 14'd999; frm_typed = 1'b0; frm_err = 5'b00110;
      repeat (3) @(negedge clk);
      frm_valid = 1'b0;
      poll_pulse();
      repeat (3) @(negedge clk);
      chk("R8 poll without ownership keeps stall", 32'(frm_stall), 32'd1);
      sw_read(nidx * 8, v);
      chk("R8 still nothing written", v, old);
      give(nidx, 1'b0);
      repeat (2) @(negedge clk);
      chk("R9 no writeback before poll", 32'(frm_stall), 32'd1);
      sw_read(nidx * 8, v);
      chk("R9 owned descriptor untouched before poll", v, 32'h8000_0000);
      poll_pulse();
      @(negedge clk);
      chk("R9 stall released", 32'(frm_stall), 32'd0);
      sw_read(nidx * 8, v);
      chk("R9 R8 held frame written", v, exp_flags(300, 1'b1, 5'b10000));
      advance();

      // idle poll demands
      give(nidx, 1'b0);
      for (int k = 0; k < 3; k++) poll_pulse();
      @(negedge clk);
      chk("R10 idle poll keeps stall low", 32'(frm_stall), 32'd0);
      sw_read(nidx * 8, v);
      chk("R10 idle poll writes nothing", v, 32'h8000_0000);
      frame_ok(42, 1'b0, 5'b01000, "R10 R5 frame after idle polls");
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (100000) @(posedge clk);
            timed_out = 1'b1;
         end
      join_any
      disable fork;
      if (timed_out) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
      end
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule